// File: doc/BRIEF.md
# Four-Lane 7:1 Pixel Link Deserializer

This block turns a serial pixel link back into parallel words. It has four data lanes, each carrying seven bits per pixel period, and a fifth lane that carries a fixed framing pattern. Each lane is sampled once per cycle of a bit clock that runs at seven times the pixel rate. The bit clock and its phase alignment are supplied from outside. Each lane has its own 7-bit shift register. A framing state machine scans the pattern lane for the frame boundary and tracks it. Once per frame, at that boundary, all four lane fields are copied into one 28-bit output register. At the same time the block regenerates a pixel-rate clock whose falling edge falls in the middle of stable data.

The framing state machine has four states:
- **ST_OFF** is the quiescent state. Reset leads to it, and the shutdown input forces it from any state.
- **ST_OFF → ST_SEARCH** happens when shutdown is low.
- **ST_SEARCH → ST_CONFIRM** happens on the first cycle in which the pattern window matches. That cycle becomes the frame boundary.
- **ST_CONFIRM → ST_LOCKED** happens when the boundary of the third consecutive frame also matches.
- **ST_CONFIRM → ST_SEARCH** and **ST_LOCKED → ST_SEARCH** both happen on any boundary where the pattern does not match.

A narrow-link input serves 21-bit transmitters that drive only three data lanes. When it is set, the top lane is ignored.

Top module: `pixlink_deser`

## Requirements
- R1: The bit that lane n receives at position b of a frame (b = 0 for the first bit received, b from 0 to 6) appears at `pix_data[7n+b]`.
- R2: While locked, the word is loaded once per frame, on the bit-clock edge that follows the capture of the frame's last bit. It then holds for the next seven bit-clock cycles.
- R3: While locked, `pix_clk` rises on the load edge, stays high for four bit-clock cycles and stays low for three. `pix_data` changes only together with a rising edge of `pix_clk`.
- R4: The frame boundary is the bit position at which the pattern lane has just carried 1,1,0,0,0,1,1 in arrival order. This position is found for any phase at which the frames begin after search starts.
- R5: `locked` rises on the boundary edge of the third consecutive matching frame. That frame's word is presented on the same edge, together with the first rise of `pix_clk`.
- R6: Whenever `locked` is low, `pix_data` is all zero and `pix_clk` is low.
- R7: In ST_LOCKED, a frame boundary whose pattern does not match drops `locked` on that edge, blanks the outputs and restarts the search.
- R8: On the first edge at which `shutdown` is high, the outputs are blanked and `locked` drops. The shift registers are held at zero while `shutdown` stays high.
- R9: After `shutdown` is released, no word is presented until three consecutive matching frames have been received again.
- R10: When `narrow_mode` is high at a load edge, `pix_data[27:21]` is loaded as zero and lane 3 has no effect on the output.
- R11: During reset, `pix_data` is zero, `pix_clk` is low and `locked` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock, seven times the pixel rate, phase-aligned to the lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | High forces the quiescent state |
| narrow_mode | input | 1 | High selects three-lane (21-bit) operation |
| lane_din | input | 4 | Serial data lanes, one bit per lane per bit-clock cycle |
| sync_lane | input | 1 | Serial framing pattern lane |
| pix_data | output | 28 | Rebuilt parallel word, lane n in bits [7n+6:7n] |
| pix_clk | output | 1 | Regenerated pixel clock; data is stable at its falling edge |
| locked | output | 1 | Frame alignment established |

## Verification
The assertions assume that each lane bit is valid across exactly one rising edge of `clk_bit`. They also assume that `narrow_mode` changes only while the outputs are blanked, so the masking check can tie the upper field to the mode that was seen at the load edge. The stimulus drives every lane on the falling edge of the bit clock and changes `narrow_mode` only inside shutdown periods. Its corrupted frames send an all-zero pattern lane, which cannot produce a false match at an off-boundary position. After a shutdown, it shifts the frame phase by idle bits, so that the search has to find a new boundary.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

    localparam int unsigned LANES_DEF       = 4;
    localparam int unsigned BITS_DEF        = 7;
    localparam int unsigned LOCK_FRAMES_DEF = 3;
    localparam logic [6:0]  SYNC_DEF        = 7'b1100011;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_SEARCH,
        ST_CONFIRM,
        ST_LOCKED
    } fr_state_e;

endpackage

// File: rtl/pixlink_lane_shift.sv
module pixlink_lane_shift #(
    parameter int unsigned BITS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_clr,
    input  logic            din,
    output logic [BITS-1:0] q
);

    // Newest bit enters at the top, so after a full frame the first
    // bit received sits at bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (hold_clr) begin
            q <= '0;
        end else begin
            q <= {din, q[BITS-1:1]};
        end
    end

endmodule

// File: rtl/pixlink_framer.sv
module pixlink_framer
    import pixlink_pkg::*;
#(
    parameter int unsigned     BITS        = 7,
    parameter int unsigned     LOCK_FRAMES = 3,
    parameter logic [BITS-1:0] SYNC        = SYNC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shutdown,
    input  logic [BITS-1:0] sync_win,
    output logic            load_word,
    output logic            clk_hi_next,
    output logic            hold_blank,
    output logic            locked
);

    localparam int unsigned PW        = (BITS > 1) ? $clog2(BITS) : 1;
    localparam int unsigned HW        = $clog2(LOCK_FRAMES + 1);
    localparam int unsigned HIGH_BITS = (BITS + 1) / 2;
    localparam logic [PW-1:0] LAST_PH  = PW'(BITS - 1);
    localparam logic [PW-1:0] HIGH_LIM = PW'(HIGH_BITS);
    localparam logic [HW-1:0] LOCK_TGT = HW'(LOCK_FRAMES);
    localparam logic [HW-1:0] ONE_HIT  = HW'(1);

    fr_state_e     state, state_n;
    logic [PW-1:0] phase, phase_n;
    logic [HW-1:0] hits, hits_n;
    logic          pat_hit;
    logic          boundary;
    logic [PW-1:0] phase_wrap;
    logic [HW-1:0] hits_inc;

    assign pat_hit    = (sync_win == SYNC);
    assign boundary   = (phase == '0);
    assign phase_wrap = (phase == LAST_PH) ? '0 : phase + 1'b1;
    assign hits_inc   = hits + 1'b1;

    // Next-state decision
    always_comb begin
        state_n = state;
        phase_n = phase;
        hits_n  = hits;
        unique case (state)
            ST_OFF: begin
                phase_n = '0;
                hits_n  = '0;
                state_n = ST_SEARCH;
            end
            ST_SEARCH: begin
                if (pat_hit) begin
                    hits_n  = ONE_HIT;
                    phase_n = PW'(1);
                    state_n = (ONE_HIT == LOCK_TGT) ? ST_LOCKED : ST_CONFIRM;
                end else begin
                    phase_n = '0;
                end
            end
            ST_CONFIRM: begin
                phase_n = phase_wrap;
                if (boundary) begin
                    if (pat_hit) begin
                        hits_n = hits_inc;
                        if (hits_inc == LOCK_TGT) begin
                            state_n = ST_LOCKED;
                        end
                    end else begin
                        hits_n  = '0;
                        phase_n = '0;
                        state_n = ST_SEARCH;
                    end
                end
            end
            ST_LOCKED: begin
                phase_n = phase_wrap;
                if (boundary && !pat_hit) begin
                    hits_n  = '0;
                    phase_n = '0;
                    state_n = ST_SEARCH;
                end
            end
            default: begin
                state_n = ST_OFF;
            end
        endcase
        if (shutdown) begin
            state_n = ST_OFF;
            phase_n = '0;
            hits_n  = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            phase <= '0;
            hits  <= '0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            hits  <= hits_n;
        end
    end

    // Output decode
    always_comb begin
        hold_blank  = (state_n != ST_LOCKED);
        load_word   = (state_n == ST_LOCKED) && boundary;
        clk_hi_next = (state_n == ST_LOCKED) && (phase < HIGH_LIM);
        locked      = (state == ST_LOCKED);
    end

endmodule

// File: rtl/pixlink_out_stage.sv
module pixlink_out_stage #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BITS   = 7,
    parameter int unsigned WORD_W = LANES * BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_word,
    input  logic              clk_hi_next,
    input  logic              hold_blank,
    input  logic              narrow_mode,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] pix_data,
    output logic              pix_clk
);

    logic [WORD_W-1:0] masked;

    // The top lane is dropped in narrow operation
    for (genvar n = 0; n < LANES; n++) begin : g_mask
        if (n == LANES - 1) begin : g_top
            assign masked[n*BITS +: BITS] = narrow_mode ? '0 : word_in[n*BITS +: BITS];
        end else begin : g_low
            assign masked[n*BITS +: BITS] = word_in[n*BITS +: BITS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_data <= '0;
            pix_clk  <= 1'b0;
        end else if (hold_blank) begin
            pix_data <= '0;
            pix_clk  <= 1'b0;
        end else begin
            pix_clk <= clk_hi_next;
            if (load_word) begin
                pix_data <= masked;
            end
        end
    end

endmodule

// File: rtl/pixlink_deser.sv
module pixlink_deser
    import pixlink_pkg::*;
#(
    parameter int unsigned     LANES       = LANES_DEF,
    parameter int unsigned     BITS        = BITS_DEF,
    parameter int unsigned     LOCK_FRAMES = LOCK_FRAMES_DEF,
    parameter logic [BITS-1:0] SYNC        = SYNC_DEF
) (
    input  logic                  clk_bit,
    input  logic                  rst_n,
    input  logic                  shutdown,
    input  logic                  narrow_mode,
    input  logic [LANES-1:0]      lane_din,
    input  logic                  sync_lane,
    output logic [LANES*BITS-1:0] pix_data,
    output logic                  pix_clk,
    output logic                  locked
);

    localparam int unsigned WORD_W = LANES * BITS;

    logic [BITS-1:0]   lane_q [LANES];
    logic [BITS-1:0]   sync_q;
    logic [WORD_W-1:0] word_bus;
    logic              load_word;
    logic              clk_hi_next;
    logic              hold_blank;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        pixlink_lane_shift #(.BITS(BITS)) u_shift (
            .clk      (clk_bit),
            .rst_n    (rst_n),
            .hold_clr (shutdown),
            .din      (lane_din[n]),
            .q        (lane_q[n])
        );
        assign word_bus[n*BITS +: BITS] = lane_q[n];
    end

    pixlink_lane_shift #(.BITS(BITS)) u_sync_shift (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .hold_clr (shutdown),
        .din      (sync_lane),
        .q        (sync_q)
    );

    pixlink_framer #(
        .BITS        (BITS),
        .LOCK_FRAMES (LOCK_FRAMES),
        .SYNC        (SYNC)
    ) u_framer (
        .clk         (clk_bit),
        .rst_n       (rst_n),
        .shutdown    (shutdown),
        .sync_win    (sync_q),
        .load_word   (load_word),
        .clk_hi_next (clk_hi_next),
        .hold_blank  (hold_blank),
        .locked      (locked)
    );

    pixlink_out_stage #(
        .LANES  (LANES),
        .BITS   (BITS),
        .WORD_W (WORD_W)
    ) u_out (
        .clk         (clk_bit),
        .rst_n       (rst_n),
        .load_word   (load_word),
        .clk_hi_next (clk_hi_next),
        .hold_blank  (hold_blank),
        .narrow_mode (narrow_mode),
        .word_in     (word_bus),
        .pix_data    (pix_data),
        .pix_clk     (pix_clk)
    );

endmodule

// File: rtl/pixlink_deser_chk.sv
module pixlink_deser_chk #(
    parameter int unsigned WORD_W = 28,
    parameter int unsigned BITS   = 7
) (
    input logic              clk_bit,
    input logic              rst_n,
    input logic              shutdown,
    input logic              narrow_mode,
    input logic [WORD_W-1:0] pix_data,
    input logic              pix_clk,
    input logic              locked
);

    localparam int unsigned HI_LEN = (BITS + 1) / 2;
    localparam int unsigned LO_LEN = BITS - HI_LEN;

    logic [3:0] hi_run;
    logic [3:0] lo_run;

    always_ff @(posedge clk_bit or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= pix_clk ? ((hi_run == 4'hF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= !pix_clk ? ((lo_run == 4'hF) ? lo_run : lo_run + 1'b1) : '0;
        end
    end

    // R6: blanked whenever not locked
    p_blank_unlocked_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !locked |-> (!pix_clk && pix_data == '0));

    // R8: shutdown blanks on the following edge
    p_shutdown_quiet_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
        shutdown |=> (!locked && !pix_clk && pix_data == '0));

    // R3: data moves only with a rising pixel clock while locked
    p_data_on_rise_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (locked && $past(locked) && pix_data != $past(pix_data)) |-> $rose(pix_clk));

    // R3: high phase is four bit times
    p_clk_high_len_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ($fell(pix_clk) && !$past(shutdown)) |-> (hi_run == 4'(HI_LEN)));

    // R3: low phase is three bit times between locked periods
    p_clk_low_len_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ($rose(pix_clk) && $past(locked)) |-> (lo_run == 4'(LO_LEN)));

    // R5: lock and first pixel clock rise together
    p_lock_with_clk_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(locked) |-> $rose(pix_clk));

    // R10: upper field is zero when narrow operation loads a word
    p_narrow_upper_r10: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ($rose(pix_clk) && $past(narrow_mode)) |-> (pix_data[WORD_W-1:WORD_W-BITS] == '0));

endmodule

bind pixlink_deser pixlink_deser_chk #(
    .WORD_W (LANES * BITS),
    .BITS   (BITS)
) u_chk (
    .clk_bit     (clk_bit),
    .rst_n       (rst_n),
    .shutdown    (shutdown),
    .narrow_mode (narrow_mode),
    .pix_data    (pix_data),
    .pix_clk     (pix_clk),
    .locked      (locked)
);

// File: tb/test_pixlink_deser.sv
`timescale 1ns/1ps
module test_pixlink_deser;

    localparam logic [6:0] SYNC = 7'b1100011;

    logic        clk_bit = 1'b0;
    logic        rst_n;
    logic        shutdown;
    logic        narrow_mode;
    logic [3:0]  lane_din;
    logic        sync_lane;
    logic [27:0] pix_data;
    logic        pix_clk;
    logic        locked;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 0;

    // model state
    int          run_len  = 0;
    logic        res_lock = 1'b0;
    logic [27:0] res_word = '0;
    logic        vis_lock = 1'b0;
    logic [27:0] vis_word = '0;

    always #2.5 clk_bit = ~clk_bit;

    pixlink_deser i_pixlink_deser (
        .clk_bit     (clk_bit),
        .rst_n       (rst_n),
        .shutdown    (shutdown),
        .narrow_mode (narrow_mode),
        .lane_din    (lane_din),
        .sync_lane   (sync_lane),
        .pix_data    (pix_data),
        .pix_clk     (pix_clk),
        .locked      (locked)
    );

    task automatic chk(input string req, input string what, input logic [27:0] act, input logic [27:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
        end
    endtask

    function automatic logic [27:0] mask_word(input logic [27:0] w, input logic nar);
        return nar ? (w & 28'h01F_FFFF) : w;
    endfunction

    task automatic send_frame(input logic [27:0] w, input bit good, input bit shut, input string tag);
        for (int b = 0; b < 7; b++) begin
            @(negedge clk_bit);
            if (b == 0) begin
                chk(tag, "data at frame start", pix_data, vis_word);
                chk("R3", "pix_clk low phase", {27'd0, pix_clk}, 28'd0);
                chk("R5", "locked", {27'd0, locked}, {27'd0, vis_lock});
                if (shut) begin
                    vis_lock = 1'b0;
                    vis_word = '0;
                end else begin
                    vis_lock = res_lock;
                    vis_word = res_word;
                end
            end else begin
                chk(tag, "data", pix_data, vis_word);
                chk("R3", "pix_clk", {27'd0, pix_clk}, {27'd0, (vis_lock && b <= 4)});
                chk("R5", "locked", {27'd0, locked}, {27'd0, vis_lock});
            end
            for (int n = 0; n < 4; n++) lane_din[n] = w[7*n + b];
            if (narrow_mode) lane_din[3] = 1'($urandom);
            sync_lane = good ? SYNC[b] : 1'b0;
            shutdown  = shut;
        end
        if (shut) run_len = 0;
        else if (good) run_len++;
        else run_len = 0;
        res_lock = (run_len >= 3);
        res_word = res_lock ? mask_word(w, narrow_mode) : '0;
    endtask

    function automatic logic [27:0] rnd_word();
        return 28'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; shutdown = 1'b0; narrow_mode = 1'b0;
        lane_din = '0; sync_lane = 1'b0;
        repeat (3) @(negedge clk_bit);
        // R11: reset state
        chk("R11", "data in reset", pix_data, '0);
        chk("R11", "pix_clk in reset", {27'd0, pix_clk}, '0);
        chk("R11", "locked in reset", {27'd0, locked}, '0);
        rst_n = 1'b1;

        // R6 then R2: acquire lock, random words
        send_frame(rnd_word(), 1, 0, "R6");
        send_frame(rnd_word(), 1, 0, "R6");
        for (int i = 0; i < 8; i++) send_frame(rnd_word(), 1, 0, "R2");
        // R1: bit placement patterns
        send_frame(28'h000_0001, 1, 0, "R1");
        send_frame(28'h800_0000, 1, 0, "R1");
        send_frame(28'h020_4081, 1, 0, "R1");
        send_frame(28'hFFF_FFFF, 1, 0, "R1");
        send_frame(28'h555_5555, 1, 0, "R1");
        send_frame(rnd_word(), 1, 0, "R1");
        // R7: corrupt pattern lane while locked
        send_frame(rnd_word(), 0, 0, "R7");
        for (int i = 0; i < 5; i++) send_frame(rnd_word(), 1, 0, "R7");
        // R8: shutdown, switch to narrow operation inside it
        send_frame(rnd_word(), 1, 1, "R8");
        narrow_mode = 1'b1;
        send_frame(rnd_word(), 1, 1, "R8");
        send_frame(rnd_word(), 1, 1, "R8");
        // R4: release with a shifted frame phase
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_bit);
            chk("R9", "locked during idle", {27'd0, locked}, '0);
            lane_din = '0; sync_lane = 1'b0; shutdown = 1'b0;
        end
        for (int i = 0; i < 3; i++) send_frame(rnd_word(), 1, 0, "R9");
        // R10: three-lane operation with noise on lane 3
        for (int i = 0; i < 6; i++) send_frame(rnd_word(), 1, 0, "R10");
        send_frame(rnd_word(), 1, 1, "R8");
        narrow_mode = 1'b0;
        send_frame(rnd_word(), 1, 1, "R8");
        for (int i = 0; i < 4; i++) send_frame(rnd_word(), 1, 0, "R4");
        // random mix
        for (int i = 0; i < 200; i++) begin
            int unsigned r;
            r = $urandom_range(99);
            if (r < 4) send_frame(rnd_word(), 1, 1, "R8");
            else if (r < 9) send_frame(rnd_word(), 0, 0, "R7");
            else send_frame(rnd_word(), 1, 0, "R2");
        end
        send_frame(rnd_word(), 1, 0, "R2");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_bit);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule